// File: doc/BRIEF.md
# Monitor Readback Serial Target

This block is the serial-bus front end of a voltage and current monitor. It oversamples the open-drain clock and data lines with the system clock and finds start and stop conditions. It answers one 7-bit address and shifts bytes in and out in nine-clock frames. It pulls the data line low to acknowledge and to send zero bits.

A write carries a command byte. The command picks the readback format and can ask for a new conversion. A conversion can also be requested by a rising edge on a dedicated pin. The converter model outside the block loads fresh results with a one-cycle load strobe. The block has no back-pressure on that strobe, so every strobe is taken. On a read, the block freezes a copy of both 12-bit results. It then streams that copy out as two bytes (one quantity) or three bytes (both quantities packed).

Top module: `mon_i2c_target`

## Requirements
- R1: The target address is {3'b011, strap_a1, strap_a0}, with strap_a1 as bits 3:2 and strap_a0 as bits 1:0. It is sent MSB first and followed by a direction bit (0 write, 1 read). On a match the target holds SDA low for the ninth clock.
- R2: On an address mismatch the target does not acknowledge and never drives SDA until the next start condition.
- R3: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. Both release SDA in the following cycle. A start always restarts address reception, which also makes repeated starts work.
- R4: sda_oe changes only while the sampled SCL is low.
- R5: Bits 1:0 of the first byte after a write address select the read format: 00 voltage, 01 current, 10 or 11 both packed. After reset the format is both packed. Later bytes of the same write are acknowledged and ignored.
- R6: A command byte with bit 7 set produces exactly one single-cycle conv_start pulse. The command byte is acknowledged.
- R7: A rising edge on conv_pin produces exactly one single-cycle conv_start pulse, however long the pin stays high.
- R8: In a one-quantity format, byte 0 carries result bits 11:4. Byte 1 carries bits 3:0 in its upper nibble, and its lower nibble is zero.
- R9: In the packed format, byte 0 is voltage[11:4] and byte 1 is current[11:4]. Byte 2 is {voltage[3:0], current[3:0]}. Bytes past the end of any format read as 8'h00.
- R10: The results are copied when a read address is matched. A res_load during the read does not change the bytes of that read.
- R11: After the controller does not acknowledge a read byte, the target leaves SDA released until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a1 | input | 2 | Resolved code of the upper strap, address bits 3:2 |
| strap_a0 | input | 2 | Resolved code of the lower strap, address bits 1:0 |
| conv_pin | input | 1 | Asynchronous conversion request, acts on rising edge |
| res_load | input | 1 | One-cycle strobe that loads volt_in and curr_in |
| volt_in | input | 12 | Voltage result from the converter |
| curr_in | input | 12 | Current result from the converter |
| conv_start | output | 1 | One-cycle conversion request to the converter |

## Verification
The main function is tried with random strap codes paired with random results in every format. A wrong byte order or wrong nibble packing shows up as a miscompare. The bench also sends addresses that differ from the strapped one only in the prefix or in a single strap bit. These show whether the comparison covers all seven bits. Commands with and without bit 7 set, plus long and short pulses on the convert pin, separate a level response from an edge response. A load in the middle of a read, reads past the end of a format, and clocks sent after a not-acknowledge test the snapshot and the release rules.

// File: rtl/mon_i2c_pkg.sv
package mon_i2c_pkg;
  typedef enum logic [2:0] {
    CT_IDLE,
    CT_SHIFT,
    CT_ACK_WAIT,
    CT_ACK,
    CT_TX,
    CT_MACK,
    CT_TX_LOAD
  } ctl_state_t;

  localparam logic [1:0] FMT_VOLT = 2'b00;
  localparam logic [1:0] FMT_CURR = 2'b01;
  localparam logic [1:0] FMT_BOTH = 2'b10;
endpackage

// File: rtl/mon_i2c_sync.sv
module mon_i2c_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mon_i2c_cond.sv
module mon_i2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/mon_i2c_packer.sv
module mon_i2c_packer #(
  parameter int RES_W = 12,
  parameter int IDX_W = 2
) (
  input  logic [1:0]       fmt,
  input  logic [IDX_W-1:0] idx,
  input  logic [RES_W-1:0] volt,
  input  logic [RES_W-1:0] curr,
  output logic [7:0]       tx_byte
);
  import mon_i2c_pkg::*;
  localparam int LO_W = RES_W - 8;

  logic [7:0] v_hi, c_hi, v_lo, c_lo, pack_lo;

  assign v_hi    = volt[RES_W-1 -: 8];
  assign c_hi    = curr[RES_W-1 -: 8];
  assign v_lo    = {volt[LO_W-1:0], {(8-LO_W){1'b0}}};
  assign c_lo    = {curr[LO_W-1:0], {(8-LO_W){1'b0}}};
  assign pack_lo = {volt[LO_W-1:0], curr[LO_W-1:0]};

  always_comb begin
    tx_byte = 8'h00;
    unique case (fmt)
      FMT_VOLT: begin
        if (idx == 0) tx_byte = v_hi;
        else if (idx == 1) tx_byte = v_lo;
      end
      FMT_CURR: begin
        if (idx == 0) tx_byte = c_hi;
        else if (idx == 1) tx_byte = c_lo;
      end
      default: begin
        if (idx == 0) tx_byte = v_hi;
        else if (idx == 1) tx_byte = c_hi;
        else if (idx == 2) tx_byte = pack_lo;
      end
    endcase
  end
endmodule

// File: rtl/mon_i2c_ctrl.sv
module mon_i2c_ctrl #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic [6:0]       own_addr,
  input  logic [7:0]       tx_byte,
  output logic             sda_oe,
  output logic [1:0]       fmt,
  output logic             cmd_conv,
  output logic             snap,
  output logic [IDX_W-1:0] byte_idx,
  output logic             ctl_idle
);
  import mon_i2c_pkg::*;
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  ctl_state_t  state;
  logic [6:0]  rx_sr;
  logic [7:0]  tx_sr;
  logic [2:0]  bit_cnt;
  logic        addr_phase, matched, is_read, cmd_pending;
  logic [7:0]  rx_byte;

  assign rx_byte  = {rx_sr, sda_s};
  assign ctl_idle = (state == CT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= CT_IDLE;
      rx_sr       <= '0;
      tx_sr       <= '0;
      bit_cnt     <= '0;
      addr_phase  <= 1'b0;
      matched     <= 1'b0;
      is_read     <= 1'b0;
      cmd_pending <= 1'b0;
      sda_oe      <= 1'b0;
      fmt         <= FMT_BOTH;
      cmd_conv    <= 1'b0;
      snap        <= 1'b0;
      byte_idx    <= '0;
    end else begin
      cmd_conv <= 1'b0;
      snap     <= 1'b0;
      if (start_det) begin
        state      <= CT_SHIFT;
        bit_cnt    <= '0;
        addr_phase <= 1'b1;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        state  <= CT_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          CT_IDLE: ;
          CT_SHIFT: if (scl_rise) begin
            rx_sr <= rx_byte[6:0];
            if (bit_cnt == 3'd7) begin
              bit_cnt    <= '0;
              state      <= CT_ACK_WAIT;
              addr_phase <= 1'b0;
              if (addr_phase) begin
                matched     <= (rx_byte[7:1] == own_addr);
                is_read     <= rx_byte[0];
                cmd_pending <= ~rx_byte[0];
                byte_idx    <= '0;
                if ((rx_byte[7:1] == own_addr) && rx_byte[0]) snap <= 1'b1;
              end else if (cmd_pending) begin
                fmt         <= rx_byte[1:0];
                cmd_conv    <= rx_byte[7];
                cmd_pending <= 1'b0;
              end
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          CT_ACK_WAIT: if (scl_fall) begin
            if (matched) begin
              sda_oe <= 1'b1;
              state  <= CT_ACK;
            end else begin
              state <= CT_IDLE;
            end
          end
          CT_ACK, CT_TX_LOAD: if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              tx_sr  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              state  <= CT_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= CT_SHIFT;
            end
          end
          CT_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= CT_MACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
              sda_oe  <= ~tx_sr[6];
            end
          end
          CT_MACK: if (scl_rise) begin
            if (!sda_s) begin
              if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
              state <= CT_TX_LOAD;
            end else begin
              state <= CT_IDLE;
            end
          end
          default: state <= CT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_i2c_target.sv
module mon_i2c_target #(
  parameter int         RES_W       = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] ADDR_PREFIX = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       strap_a1,
  input  logic [1:0]       strap_a0,
  input  logic             conv_pin,
  input  logic             res_load,
  input  logic [RES_W-1:0] volt_in,
  input  logic [RES_W-1:0] curr_in,
  output logic             conv_start
);
  localparam int N_SYNC = 3;
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011;
  localparam int IDX_W = 2;

  logic [N_SYNC-1:0] raw_in, synced;
  logic scl_s, sda_s, pin_s, pin_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [RES_W-1:0] volt_r, curr_r, volt_snap, curr_snap;
  logic [1:0] fmt;
  logic cmd_conv, snap, ctl_idle;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0] tx_byte;
  logic [6:0] own_addr;

  assign raw_in = {conv_pin, sda_i, scl_i};

  genvar gi;
  generate
    for (gi = 0; gi < N_SYNC; gi++) begin : g_sync
      mon_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[gi])) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in[gi]), .q(synced[gi]));
    end
  endgenerate

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign pin_s    = synced[2];
  assign own_addr = {ADDR_PREFIX, strap_a1, strap_a0};

  mon_i2c_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  mon_i2c_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_oe(sda_oe), .fmt(fmt),
    .cmd_conv(cmd_conv), .snap(snap), .byte_idx(byte_idx), .ctl_idle(ctl_idle));

  mon_i2c_packer #(.RES_W(RES_W), .IDX_W(IDX_W)) u_pack (
    .fmt(fmt), .idx(byte_idx), .volt(volt_snap), .curr(curr_snap),
    .tx_byte(tx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volt_r     <= '0;
      curr_r     <= '0;
      volt_snap  <= '0;
      curr_snap  <= '0;
      pin_q      <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (res_load) begin
        volt_r <= volt_in;
        curr_r <= curr_in;
      end
      if (snap) begin
        volt_snap <= volt_r;
        curr_snap <= curr_r;
      end
      pin_q      <= pin_s;
      conv_start <= cmd_conv | (pin_s & ~pin_q);
    end
  end
endmodule

// File: rtl/mon_i2c_target_chk.sv
module mon_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_det,
  input logic stop_det,
  input logic ctl_idle
);
  // R4
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_idle |-> !sda_oe);
endmodule

bind mon_i2c_target mon_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .ctl_idle(ctl_idle));

// File: tb/mon_i2c_target_test.sv
module mon_i2c_target_test;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_ctl = 1'b1;
  logic sda_oe, conv_start;
  logic [1:0] a1 = 2'd0, a0 = 2'd0;
  logic conv_pin = 1'b0, res_load = 1'b0;
  logic [11:0] volt_in = '0, curr_in = '0;
  logic sda_line;
  int checks = 0, fails = 0, conv_cnt = 0, r4_viol = 0;
  logic oe_prev = 1'b0;

  assign sda_line = sda_ctl & ~sda_oe;
  always #2.5 clk = ~clk;

  mon_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a1(a1), .strap_a0(a0), .conv_pin(conv_pin), .res_load(res_load),
    .volt_in(volt_in), .curr_in(curr_in), .conv_start(conv_start));

  always @(posedge clk) if (conv_start) conv_cnt++;
  always @(negedge clk) begin
    if (scl && (sda_oe != oe_prev)) r4_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic v);
    sda_ctl = v; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic bit_in(output logic v);
    sda_ctl = 1'b1; qw(); scl = 1'b1; qw(); v = sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; qw(); scl = 1'b1; qw(); sda_ctl = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; qw(); scl = 1'b1; qw(); sda_ctl = 1'b1; qw();
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~give_ack);
  endtask

  task automatic load(input logic [11:0] v, input logic [11:0] c);
    @(negedge clk); volt_in = v; curr_in = c; res_load = 1'b1;
    @(negedge clk); res_load = 1'b0;
  endtask

  function automatic logic [6:0] addr_of(input logic [1:0] s1, input logic [1:0] s0);
    return {3'b011, s1, s0};
  endfunction

  function automatic int fmt_len(input logic [1:0] f);
    return (f[1]) ? 3 : 2;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] f, input int idx,
                                          input logic [11:0] v, input logic [11:0] c);
    logic [11:0] one;
    one = (f == 2'b01) ? c : v;
    if (f[1]) begin
      if (idx == 0) return v[11:4];
      if (idx == 1) return c[11:4];
      if (idx == 2) return {v[3:0], c[3:0]};
      return 8'h00;
    end
    if (idx == 0) return one[11:4];
    if (idx == 1) return {one[3:0], 4'h0};
    return 8'h00;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [1:0] f;
    logic [11:0] v, c;
    int cbase;
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 reset sda_oe", sda_oe, 0);
    chk("R6 reset conv_start", conv_start, 0);

    // R5 R9: default format is packed, no command needed
    a1 = 2'd2; a0 = 2'd1;
    load(12'hABC, 12'h123);
    bus_start(); send({addr_of(a1, a0), 1'b1}, ack);
    chk("R1 read ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      recv(i < 2, b);
      chk("R9 default packed", b, exp_byte(2'b10, i, 12'hABC, 12'h123));
    end
    // R11: clocks after nack see released line
    recv(1'b0, b);
    chk("R11 released after nack", b, 8'hFF);
    bus_stop();

    // R2: prefix mismatch and single strap bit mismatch
    bus_start(); send({3'b010, a1, a0, 1'b1}, ack);
    chk("R2 prefix mismatch nack", ack, 0);
    recv(1'b1, b);
    chk("R2 no drive after mismatch", b, 8'hFF);
    bus_stop();
    bus_start(); send({3'b011, a1, a0 ^ 2'b01, 1'b0}, ack);
    chk("R2 strap bit mismatch nack", ack, 0);
    bus_stop();

    // R6: command with bit7, format voltage, then R8 and past-end R9
    cbase = conv_cnt;
    bus_start(); send({addr_of(a1, a0), 1'b0}, ack);
    chk("R1 write ack", ack, 1);
    send(8'h80, ack);
    chk("R6 command ack", ack, 1);
    send(8'h01, ack);
    chk("R5 extra byte ack", ack, 1);
    chk("R6 one pulse", conv_cnt - cbase, 1);
    load(12'h5E7, 12'h9D2);
    bus_start(); send({addr_of(a1, a0), 1'b1}, ack);
    for (int i = 0; i < 3; i++) begin
      recv(i < 2, b);
      chk("R8 voltage format, R9 past end", b, exp_byte(2'b00, i, 12'h5E7, 12'h9D2));
    end
    bus_stop();

    // R10: load mid-read does not disturb the transfer
    bus_start(); send({addr_of(a1, a0), 1'b0}, ack); send(8'h02, ack);
    bus_start(); send({addr_of(a1, a0), 1'b1}, ack);
    recv(1'b1, b);
    chk("R10 byte0", b, exp_byte(2'b10, 0, 12'h5E7, 12'h9D2));
    load(12'h111, 12'h222);
    recv(1'b1, b);
    chk("R10 byte1", b, exp_byte(2'b10, 1, 12'h5E7, 12'h9D2));
    recv(1'b0, b);
    chk("R10 byte2", b, exp_byte(2'b10, 2, 12'h5E7, 12'h9D2));
    bus_stop();

    // R7: long and short pin pulses
    cbase = conv_cnt;
    @(negedge clk); conv_pin = 1'b1; repeat (40) @(negedge clk); conv_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 long pulse once", conv_cnt - cbase, 1);
    conv_pin = 1'b1; repeat (3) @(negedge clk); conv_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 short pulse once", conv_cnt - cbase, 2);

    // random transactions
    for (int t = 0; t < 20; t++) begin
      logic cv;
      a1 = 2'($urandom); a0 = 2'($urandom);
      v = 12'($urandom); c = 12'($urandom);
      f = 2'($urandom); cv = 1'($urandom);
      load(v, c);
      cbase = conv_cnt;
      bus_start(); send({addr_of(a1, a0), 1'b0}, ack);
      chk("R1 random write ack", ack, 1);
      send({cv, 5'b0, f}, ack);
      chk("R6 random conv count", conv_cnt - cbase, int'(cv));
      bus_start(); send({addr_of(a1, a0), 1'b1}, ack);
      chk("R1 random read ack", ack, 1);
      for (int i = 0; i < fmt_len(f); i++) begin
        recv(i < fmt_len(f) - 1, b);
        chk("R5 R8 R9 random byte", b, exp_byte(f, i, v, c));
      end
      bus_stop();
    end

    chk("R4 no sda change while scl high", r4_viol, 0);
    summary();
  end
endmodule